// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading two levels of translation entries from memory: first a directory entry, then a table entry. A request carries the linear address and three access flags: write, user mode and code fetch. The walker issues one 32-bit read for each level over a simple request/valid memory port. It then merges the privilege bits of both entries and checks the access against a 32-entry permission map.

A walk ends in one of two ways. It can complete, giving a physical address plus a fill record for a translation cache. It can also end in a page fault, reported with the linear address and status bits. Only one walk runs at a time. New requests are accepted only while the walker is idle. Large pages, updating the accessed or dirty bits, and raising the exception itself are left to neighbouring logic.

Top module: `page_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req`, `done_valid`, `fault_valid` and `fill_valid` are 0.
- R2: The first memory read of a walk uses address {`dir_base`[31:12], `req_laddr`[31:22], 2'b00}. The low 12 bits of `dir_base` have no effect.
- R3: The second read uses address {directory entry[31:12], linear[21:12], 2'b00}. It is issued only after the directory read returns an entry with bit 0 (present) set.
- R4: On success `done_valid` pulses for one cycle, with `done_paddr` = {table entry[31:12], linear[11:0]}. The walker then returns to idle.
- R5: A directory entry with bit 0 clear ends the walk with a fault and `fault_present`=0. No table read is issued and no fill is sent.
- R6: A table entry with bit 0 clear ends the walk with a fault and `fault_present`=0, and no fill is sent.
- R7: The permission index has five bits, from bit 0 to bit 4:
  - bit 0: request write.
  - bit 1: AND of the two entries' bit 1 (writable).
  - bit 2: AND of the two entries' bit 2 (user).
  - bit 3: request user mode.
  - bit 4: `wp_en`.
  A 0 at that index of `ALLOW_MAP` ends the walk with a fault and `fault_present`=1.
- R8: The default `ALLOW_MAP` lets a user access through only when both entries grant user access, and for a write, also both grant write access. A supervisor read is always allowed. A supervisor write to a non-writable page is refused only when `wp_en` is 1.
- R9: `fill_valid` is high in exactly the cycle of `done_valid`. It carries the linear address, the table entry, the combined {user, writable} pair and the code-fetch flag.
- R10: Only one walk is outstanding. `req_ready` is 0 from the cycle after acceptance until the walk ends, and `req_valid` or a changed `req_laddr` during that time has no effect on the walk.
- R11: While `mem_req` is high and `mem_valid` is low, `mem_req` stays high and `mem_addr` stays unchanged.
- R12: A fault reports the request's linear address, write flag and user flag on `fault_laddr`, `fault_wr` and `fault_user`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_laddr | input | 32 | Linear address to translate |
| req_wr | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| req_code | input | 1 | Access is an instruction fetch |
| dir_base | input | 32 | Directory base, bits 31:12 used |
| wp_en | input | 1 | Supervisor write-protect enable |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_valid | input | 1 | Read data valid, one cycle |
| mem_rdata | input | 32 | Read data |
| done_valid | output | 1 | Translation complete pulse |
| done_paddr | output | 32 | Physical address |
| fault_valid | output | 1 | Page fault pulse |
| fault_laddr | output | 32 | Faulting linear address |
| fault_wr | output | 1 | Faulting access was a write |
| fault_user | output | 1 | Faulting access was from user mode |
| fault_present | output | 1 | 1 = protection fault, 0 = not present |
| fill_valid | output | 1 | Cache fill pulse |
| fill_laddr | output | 32 | Fill linear address |
| fill_pte | output | 32 | Fill table entry |
| fill_wu | output | 2 | Combined {user, writable} |
| fill_code | output | 1 | Fill is for the instruction cache |

## Verification
The bench builds the walker with the default `ALLOW_MAP`. This makes the supervisor/user and write-protect rules observable through ordinary port values: request flags, the writable and user bits of the two entries, and `wp_en`. The bench's memory model answers after a multi-cycle delay, so the hold behaviour of the read port is exercised on every read. Walks at the all-zero and all-ones address corners stress the index slicing of both levels.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int ADDR_W   = 32;
  localparam int OFS_W    = 12;
  localparam int SLOT_W   = 10;
  localparam int IDX_W    = 5;
  localparam int MAP_N    = 1 << IDX_W;
  localparam int BIT_PRES = 0;
  localparam int BIT_WR   = 1;
  localparam int BIT_US   = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DIR, ST_RD_TBL, ST_CHECK, ST_DONE, ST_FAULT
  } walk_st_e;

  function automatic logic [ADDR_W-1:0] dir_slot_addr(
      input logic [ADDR_W-1:0] base, input logic [ADDR_W-1:0] la);
    return {base[ADDR_W-1:OFS_W], la[ADDR_W-1:OFS_W+SLOT_W], 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] tbl_slot_addr(
      input logic [ADDR_W-1:0] dent, input logic [ADDR_W-1:0] la);
    return {dent[ADDR_W-1:OFS_W], la[OFS_W+SLOT_W-1:OFS_W], 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] frame_addr(
      input logic [ADDR_W-1:0] tent, input logic [ADDR_W-1:0] la);
    return {tent[ADDR_W-1:OFS_W], la[OFS_W-1:0]};
  endfunction

  function automatic logic [IDX_W-1:0] perm_index(
      input logic wr, input logic user, input logic wp,
      input logic [ADDR_W-1:0] dent, input logic [ADDR_W-1:0] tent);
    return {wp, user, dent[BIT_US] & tent[BIT_US],
            dent[BIT_WR] & tent[BIT_WR], wr};
  endfunction

  function automatic logic [MAP_N-1:0] default_allow();
    logic [MAP_N-1:0] m;
    for (int i = 0; i < MAP_N; i++) begin
      logic w, ew, eu, us, wp;
      w  = i[0];
      ew = i[1];
      eu = i[2];
      us = i[3];
      wp = i[4];
      m[i] = us ? (eu && (!w || ew)) : (!w || ew || !wp);
    end
    return m;
  endfunction
endpackage

// File: rtl/pgw_addr.sv
module pgw_addr
  import pgw_pkg::*;
(
  input  logic [ADDR_W-1:0] dir_base,
  input  logic [ADDR_W-1:0] laddr,
  input  logic [ADDR_W-1:0] dent,
  input  logic [ADDR_W-1:0] tent,
  input  logic              sel_tbl,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] paddr
);
  logic [ADDR_W-1:0] a_dir, a_tbl;
  always_comb begin
    a_dir   = dir_slot_addr(dir_base, laddr);
    a_tbl   = tbl_slot_addr(dent, laddr);
    rd_addr = sel_tbl ? a_tbl : a_dir;
    paddr   = frame_addr(tent, laddr);
  end
endmodule

// File: rtl/pgw_perm.sv
module pgw_perm
  import pgw_pkg::*;
#(
  parameter logic [MAP_N-1:0] ALLOW_MAP = default_allow()
) (
  input  logic              wr,
  input  logic              user,
  input  logic              wp,
  input  logic [ADDR_W-1:0] dent,
  input  logic [ADDR_W-1:0] tent,
  output logic [IDX_W-1:0]  idx,
  output logic              allow,
  output logic [1:0]        comb_wu
);
  always_comb begin
    idx     = perm_index(wr, user, wp, dent, tent);
    allow   = ALLOW_MAP[idx];
    comb_wu = {dent[BIT_US] & tent[BIT_US], dent[BIT_WR] & tent[BIT_WR]};
  end
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pgw_pkg::*;
#(
  parameter logic [MAP_N-1:0] ALLOW_MAP = default_allow()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_laddr,
  input  logic              req_wr,
  input  logic              req_user,
  input  logic              req_code,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              wp_en,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              done_valid,
  output logic [ADDR_W-1:0] done_paddr,
  output logic              fault_valid,
  output logic [ADDR_W-1:0] fault_laddr,
  output logic              fault_wr,
  output logic              fault_user,
  output logic              fault_present,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_laddr,
  output logic [ADDR_W-1:0] fill_pte,
  output logic [1:0]        fill_wu,
  output logic              fill_code
);
  walk_st_e          st_q, st_d;
  logic [ADDR_W-1:0] la_q, dent_q, tent_q;
  logic              wr_q, us_q, code_q, prot_q;

  // named internal events
  logic walk_accept, dir_ret, tbl_ret, perm_deny;
  logic [IDX_W-1:0]  perm_idx;
  logic              perm_ok;
  logic [1:0]        wu_comb;
  logic [ADDR_W-1:0] paddr_w;

  pgw_addr u_addr (
    .dir_base (dir_base),
    .laddr    (la_q),
    .dent     (dent_q),
    .tent     (tent_q),
    .sel_tbl  (st_q == ST_RD_TBL),
    .rd_addr  (mem_addr),
    .paddr    (paddr_w)
  );

  pgw_perm #(.ALLOW_MAP(ALLOW_MAP)) u_perm (
    .wr      (wr_q),
    .user    (us_q),
    .wp      (wp_en),
    .dent    (dent_q),
    .tent    (tent_q),
    .idx     (perm_idx),
    .allow   (perm_ok),
    .comb_wu (wu_comb)
  );

  assign req_ready   = (st_q == ST_IDLE);
  assign walk_accept = req_valid && req_ready;
  assign mem_req     = (st_q == ST_RD_DIR) || (st_q == ST_RD_TBL);
  assign dir_ret     = (st_q == ST_RD_DIR) && mem_valid;
  assign tbl_ret     = (st_q == ST_RD_TBL) && mem_valid;
  assign perm_deny   = (st_q == ST_CHECK) && !perm_ok;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (walk_accept) st_d = ST_RD_DIR;
      ST_RD_DIR: if (mem_valid) st_d = mem_rdata[BIT_PRES] ? ST_RD_TBL : ST_FAULT;
      ST_RD_TBL: if (mem_valid) st_d = mem_rdata[BIT_PRES] ? ST_CHECK : ST_FAULT;
      ST_CHECK:  st_d = perm_ok ? ST_DONE : ST_FAULT;
      ST_DONE:   st_d = ST_IDLE;
      ST_FAULT:  st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      la_q   <= '0;
      dent_q <= '0;
      tent_q <= '0;
      wr_q   <= 1'b0;
      us_q   <= 1'b0;
      code_q <= 1'b0;
      prot_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (walk_accept) begin
        la_q   <= req_laddr;
        wr_q   <= req_wr;
        us_q   <= req_user;
        code_q <= req_code;
        prot_q <= 1'b0;
      end
      if (dir_ret)   dent_q <= mem_rdata;
      if (tbl_ret)   tent_q <= mem_rdata;
      if (perm_deny) prot_q <= 1'b1;
    end
  end

  assign done_valid    = (st_q == ST_DONE);
  assign done_paddr    = paddr_w;
  assign fault_valid   = (st_q == ST_FAULT);
  assign fault_laddr   = la_q;
  assign fault_wr      = wr_q;
  assign fault_user    = us_q;
  assign fault_present = prot_q;
  assign fill_valid    = (st_q == ST_DONE);
  assign fill_laddr    = la_q;
  assign fill_pte      = tent_q;
  assign fill_wu       = wu_comb;
  assign fill_code     = code_q;
endmodule

// File: rtl/pgw_chk.sv
module pgw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        walk_accept,
  input logic        dir_ret,
  input logic        tbl_ret,
  input logic [31:0] mem_rdata,
  input logic        mem_req,
  input logic        mem_valid,
  input logic [31:0] mem_addr,
  input logic        req_ready,
  input logic        done_valid,
  input logic        fault_valid,
  input logic        fault_present,
  input logic        fill_valid
);
  AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    walk_accept |=> !req_ready); // R10
  AST_DIR_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_ret && !mem_rdata[0]) |=> (fault_valid && !fault_present && !mem_req)); // R5
  AST_TBL_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_ret && !mem_rdata[0]) |=> (fault_valid && !fault_present && !fill_valid)); // R6
  AST_TBL_AFTER_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_ret && mem_rdata[0]) |=> mem_req); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && req_ready)); // R4
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R11
endmodule

bind page_walker pgw_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .walk_accept   (walk_accept),
  .dir_ret       (dir_ret),
  .tbl_ret       (tbl_ret),
  .mem_rdata     (mem_rdata),
  .mem_req       (mem_req),
  .mem_valid     (mem_valid),
  .mem_addr      (mem_addr),
  .req_ready     (req_ready),
  .done_valid    (done_valid),
  .fault_valid   (fault_valid),
  .fault_present (fault_present),
  .fill_valid    (fill_valid)
);

// File: tb/page_walker_test.sv
module page_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic        req_wr = 1'b0, req_user = 1'b0, req_code = 1'b0;
  logic [31:0] dir_base = '0;
  logic        wp_en = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done_valid, fault_valid, fault_wr, fault_user, fault_present;
  logic [31:0] done_paddr, fault_laddr, fill_laddr, fill_pte;
  logic        fill_valid, fill_code;
  logic [1:0]  fill_wu;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  page_walker uut (.*);

  // memory model state
  logic [31:0] ent_dir, ent_tbl;
  logic [31:0] seen_addr [2];
  int          rd_cnt;
  int          hold_bad;
  localparam int LAT = 3;

  initial begin
    int wait_cnt;
    logic [31:0] first;
    wait_cnt = 0;
    first = '0;
    forever begin
      @(negedge clk);
      mem_valid = 1'b0;
      if (mem_req) begin
        wait_cnt++;
        if (wait_cnt == 1) first = mem_addr;
        if (wait_cnt == LAT) begin
          if (mem_addr !== first) hold_bad++;
          if (rd_cnt < 2) seen_addr[rd_cnt] = mem_addr;
          mem_rdata = (rd_cnt == 0) ? ent_dir : ent_tbl;
          mem_valid = 1'b1;
          rd_cnt++;
          wait_cnt = 0;
        end
      end else begin
        wait_cnt = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] la;
    logic [31:0] base;
    logic [31:0] dent;
    logic [31:0] tent;
    logic        wr;
    logic        us;
    logic        code;
    logic        wp;
    logic        exp_fault;
    logic        exp_prot;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{32'h12345678, 32'h00100000, 32'h00200007, 32'h00ABC007, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h0040A123, 32'h00300000, 32'h00500007, 32'h01234007, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{32'h80001ABC, 32'h00300000, 32'h00600007, 32'h00777005, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h80001ABC, 32'h00300000, 32'h00600007, 32'h00777005, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{32'hC0402000, 32'h00300000, 32'h00600003, 32'h00888007, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{32'h00C03FF0, 32'h00400000, 32'h00700007, 32'h00999001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h00C03FF0, 32'h00400000, 32'h00700007, 32'h00999001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    '{32'h55555555, 32'h00400000, 32'h00700006, 32'h00999007, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{32'hAAAAAAAA, 32'h00400000, 32'h00700007, 32'h00999006, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{32'hFFFFFFFF, 32'hFFFFF000, 32'hFFFFE007, 32'hFFFFF007, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h00000000, 32'h00000ABC, 32'h00001007, 32'h00002007, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h01001234, 32'h00400000, 32'h00700005, 32'h00999003, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  // Runs one walk; when busy_poke is set, req_valid stays high with another
  // address during the walk (R10).
  task automatic run_walk(input vec_t v, input bit busy_poke);
    logic [31:0] exp_dir_a, exp_tbl_a, exp_pa;
    logic        got_done, got_fault, ready_leak;
    logic [1:0]  exp_wu;
    exp_dir_a = (v.base & 32'hFFFFF000) + ((v.la >> 20) & 32'h00000FFC);
    exp_tbl_a = (v.dent & 32'hFFFFF000) + ((v.la >> 10) & 32'h00000FFC);
    exp_pa    = (v.tent & 32'hFFFFF000) | (v.la & 32'h00000FFF);
    exp_wu    = {v.dent[2] & v.tent[2], v.dent[1] & v.tent[1]};
    ent_dir = v.dent;
    ent_tbl = v.tent;
    rd_cnt = 0;
    seen_addr[0] = 'x;
    seen_addr[1] = 'x;
    @(negedge clk);
    req_laddr = v.la; req_wr = v.wr; req_user = v.us; req_code = v.code;
    dir_base = v.base; wp_en = v.wp; req_valid = 1'b1;
    @(negedge clk);
    if (busy_poke) req_laddr = 32'hDEAD_B000;
    else req_valid = 1'b0;
    got_done = 1'b0; got_fault = 1'b0; ready_leak = 1'b0;
    for (int t = 0; t < 60 && !got_done && !got_fault; t++) begin
      if (done_valid) got_done = 1'b1;
      else if (fault_valid) got_fault = 1'b1;
      else begin
        if (req_ready) ready_leak = 1'b1;
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    chk(!ready_leak, "R10", "req_ready low while busy", {31'b0, ready_leak}, 32'h0);
    chk(seen_addr[0] === exp_dir_a, "R2", "directory address", seen_addr[0], exp_dir_a);
    if (v.dent[0])
      chk(seen_addr[1] === exp_tbl_a, "R3", "table address", seen_addr[1], exp_tbl_a);
    else
      chk(rd_cnt == 1, "R5", "no table read after absent directory", rd_cnt, 1);
    chk(got_fault == v.exp_fault && (got_done || got_fault), "R7",
        "fault outcome", {31'b0, got_fault}, {31'b0, v.exp_fault});
    if (got_done) begin
      chk(done_paddr === exp_pa, "R4", "physical address", done_paddr, exp_pa);
      chk(fill_valid === 1'b1, "R9", "fill with done", {31'b0, fill_valid}, 32'h1);
      chk(fill_laddr === v.la && fill_pte === v.tent, "R9", "fill laddr/entry",
          fill_laddr, v.la);
      chk(fill_wu === exp_wu && fill_code === v.code, "R9", "fill perm/code",
          {29'b0, fill_code, fill_wu}, {29'b0, v.code, exp_wu});
      @(negedge clk);
      chk(!done_valid && req_ready, "R4", "done single pulse then idle",
          {30'b0, done_valid, req_ready}, 32'h1);
    end
    if (got_fault) begin
      chk(fill_valid === 1'b0, "R6", "no fill on fault", {31'b0, fill_valid}, 32'h0);
      chk(fault_present === v.exp_prot, (v.exp_prot ? "R8" : "R6"), "fault present bit",
          {31'b0, fault_present}, {31'b0, v.exp_prot});
      chk(fault_laddr === v.la && fault_wr === v.wr && fault_user === v.us, "R12",
          "fault report", fault_laddr, v.la);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    hold_bad = 0;
    ent_dir = '0;
    ent_tbl = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready === 1'b1 && mem_req === 1'b0, "R1", "reset ready/mem_req",
        {30'b0, req_ready, mem_req}, 32'h2);
    chk(!done_valid && !fault_valid && !fill_valid, "R1", "reset result pulses",
        {29'b0, done_valid, fault_valid, fill_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_walk(VEC[i], 1'b0);

    // R10: request held high with another address while busy
    run_walk(VEC[0], 1'b1);
    // R8: supervisor read on a read-only user-less page with write protect
    run_walk('{32'h00402040, 32'h00100000, 32'h00200001, 32'h00345001,
               1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, 1'b0);
    // R11: read address stayed put across each wait
    chk(hold_bad == 0, "R11", "address stable while waiting", hold_bad, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule